// File: doc/BRIEF.md
# Prioritized Interrupt Vector Selector

This block keeps an enable bit and a pending bit for each maskable interrupt source of a small controller. When the core runs its vector-select instruction, the block looks at the sources that are enabled and pending. It picks the one with the best fixed rank and returns the two-byte address of that source's entry in the vector table. The choice is made at the time of the select request, not when the interrupt was taken. A better-ranked source that turned active after interrupt entry therefore wins. If nothing is active, the block returns the lowest, default slot.

The table has sixteen two-byte slots. Slot index `s` runs from 0 for the lowest rank (rank 16) up to 15 for the highest rank (rank 1). Slot `s` sits at low address `BASE_LO + 2*s`, which is E0h for rank 16 and FEh for rank 1. The high byte of the address is the page value supplied with the request.

Rank 1 is the non-maskable software entry and is handled elsewhere. Ranks 2, 8, 9, 10, 13 and 14 are reserved. The implemented maskable sources are ranks 3, 4, 5, 6, 7, 11, 12 and 15. Selection never clears a pending bit, so sources that lose stay pending and can raise a new interrupt later.

Top module: `irq_vec_select`

## Requirements
- R1: While reset is asserted and after it is released, all enable and pending bits are clear, `any_active` is 0, and `vec_hi` and `vec_lo` are 0.
- R2: A one-cycle pulse on `src_evt[s]` for an implemented slot `s` sets that slot's pending bit. The bit stays set for any number of cycles until a clear arrives for that slot.
- R3: A pulse on `pend_clr[s]` clears pending bit `s`. If the event and the clear for the same slot arrive in the same cycle, the bit ends up set.
- R4: A slot is active only when both its enable bit and its pending bit are set. A cycle with `en_wr` high replaces every enable bit with `en_wdata` (bit `s` is slot `s`).
- R5: The reserved ranks (slot indices 14, 8, 7, 6, 3, 2), the software slot 15 and the default slot 0 never become active, whatever their events or enable bits are. `vec_lo` never shows a reserved slot's address.
- R6: A cycle with `vsel_req` high resolves the highest-index active slot at that moment. On the next cycle `vec_lo = E0h + 2*slot` and `vec_hi = page` as sampled with the request.
- R7: If no slot is active at the request, the next cycle shows `vec_lo = E0h` (rank 16).
- R8: A select request clears no pending bits; slots that lose remain pending and active.
- R9: `any_active` is the OR of all active slots. It is registered, so it follows a change in the enable or pending bits one cycle later.
- R10: `vec_hi` and `vec_lo` hold their values in every cycle without a select request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_evt | input | 16 | Per-slot one-cycle event strobes that set pending bits |
| pend_clr | input | 16 | Per-slot one-cycle pending-clear strobes |
| en_wr | input | 1 | Write strobe for the enable bits |
| en_wdata | input | 16 | New enable bits, one per slot |
| vsel_req | input | 1 | Vector-select request |
| page | input | 8 | Vector page, used as the address high byte; nonzero |
| vec_hi | output | 8 | High byte of the selected table address |
| vec_lo | output | 8 | Low byte of the selected table address |
| any_active | output | 1 | Registered OR of all active maskable slots |

## Verification
Some properties are checked by assertions on every cycle:
- an event always leaves its pending bit set, even against a same-cycle clear;
- pending bits survive every cycle that has no clear;
- an empty active set at a request gives the default address;
- the page byte matches the request;
- the outputs hold between requests;
- a reserved address never appears.

Other behaviour can only be shown by the bench's scenarios:
- that the later, better-ranked source wins at select time;
- that an enable write masks or unmasks pending sources;
- that reserved and non-maskable slots ignore stimulus;
- that losing sources are still pending after a select;
- the one-cycle lag of `any_active`.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned NSLOT     = 16;
  localparam int unsigned SLOT_W    = $clog2(NSLOT);
  localparam int unsigned ADDR_W    = 8;
  // implemented maskable slots: ranks 3..7, 11, 12, 15
  localparam logic [NSLOT-1:0] IMPL_MASK = 16'h3E32;
  localparam logic [ADDR_W-1:0] BASE_LO  = 8'hE0;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_vec_pkg::*;
#(
  parameter int unsigned N = NSLOT,
  parameter logic [N-1:0] IMPL = IMPL_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  input  logic         en_wr,
  input  logic [N-1:0] en_wdata,
  output logic [N-1:0] active
);
  logic [N-1:0] pend_q, pend_d;
  logic [N-1:0] en_q, en_d;

  for (genvar s = 0; s < N; s++) begin : g_slot
    if (IMPL[s]) begin : g_impl
      always_comb begin
        pend_d[s] = (pend_q[s] & ~clr[s]) | evt[s];
        en_d[s]   = en_wr ? en_wdata[s] : en_q[s];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pend_q[s] <= 1'b0;
          en_q[s]   <= 1'b0;
        end else begin
          pend_q[s] <= pend_d[s];
          en_q[s]   <= en_d[s];
        end
      end
    end else begin : g_tie
      always_comb begin
        pend_d[s] = 1'b0;
        en_d[s]   = 1'b0;
        pend_q[s] = 1'b0;
        en_q[s]   = 1'b0;
      end
    end
  end

  assign active = pend_q & en_q;

  assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    |(evt & IMPL) |=> ((pend_q & $past(evt & IMPL)) == $past(evt & IMPL)));

  assert_pend_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    |(pend_q & ~clr) |=> (($past(pend_q & ~clr) & ~pend_q) == '0));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_vec_pkg::*;
#(
  parameter int unsigned N  = NSLOT,
  parameter int unsigned SW = SLOT_W
) (
  input  logic [N-1:0]  active,
  output logic [SW-1:0] win
);
  // higher slot index means better rank; slot 0 is the default
  always_comb begin
    win = '0;
    for (int i = 1; i < N - 1; i++) begin
      if (active[i]) win = SW'(i);
    end
  end
endmodule

// File: rtl/irq_vec_select.sv
module irq_vec_select
  import irq_vec_pkg::*;
#(
  parameter int unsigned N_SLOTS = NSLOT,
  parameter int unsigned AW      = ADDR_W,
  parameter logic [N_SLOTS-1:0] IMPL = IMPL_MASK,
  parameter logic [AW-1:0] BASE  = BASE_LO
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SLOTS-1:0] src_evt,
  input  logic [N_SLOTS-1:0] pend_clr,
  input  logic               en_wr,
  input  logic [N_SLOTS-1:0] en_wdata,
  input  logic               vsel_req,
  input  logic [AW-1:0]      page,
  output logic [AW-1:0]      vec_hi,
  output logic [AW-1:0]      vec_lo,
  output logic               any_active
);
  localparam int unsigned SW = $clog2(N_SLOTS);

  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [N_SLOTS-1:0] active;
  logic [SW-1:0]      win;

  irq_src_bank #(.N(N_SLOTS), .IMPL(IMPL)) u_bank (
    .clk(clk), .rst_n(rst_sync_n), .evt(src_evt), .clr(pend_clr),
    .en_wr(en_wr), .en_wdata(en_wdata), .active(active)
  );

  irq_prio_pick #(.N(N_SLOTS), .SW(SW)) u_pick (
    .active(active), .win(win)
  );

  logic [AW-1:0] hi_d, lo_d;
  logic          any_d;

  always_comb begin
    hi_d  = vec_hi;
    lo_d  = vec_lo;
    any_d = |active;
    if (vsel_req) begin
      hi_d = page;
      lo_d = BASE + AW'({win, 1'b0});
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vec_hi     <= '0;
      vec_lo     <= '0;
      any_active <= 1'b0;
    end else begin
      vec_hi     <= hi_d;
      vec_lo     <= lo_d;
      any_active <= any_d;
    end
  end

  function automatic logic lo_is_reserved(input logic [AW-1:0] lo);
    logic r;
    r = 1'b0;
    for (int s = 1; s < N_SLOTS - 1; s++)
      if (!IMPL[s] && lo == BASE + AW'(2 * s)) r = 1'b1;
    return r;
  endfunction

  assert_page_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    vsel_req |=> vec_hi == $past(page));

  assert_default_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (vsel_req && active == '0) |=> vec_lo == BASE);

  assert_no_reserved_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    vsel_req |=> !lo_is_reserved(vec_lo));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !vsel_req |=> ($stable(vec_hi) && $stable(vec_lo)));
endmodule

// File: tb/test_irq_vec_select.sv
module test_irq_vec_select;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] src_evt, pend_clr, en_wdata;
  logic        en_wr, vsel_req;
  logic [7:0]  page, vec_hi, vec_lo;
  logic        any_active;
  int          n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  irq_vec_select i_irq_vec_select (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .pend_clr(pend_clr),
    .en_wr(en_wr), .en_wdata(en_wdata), .vsel_req(vsel_req), .page(page),
    .vec_hi(vec_hi), .vec_lo(vec_lo), .any_active(any_active)
  );

  function automatic logic [15:0] rk(input int rank);
    return 16'(1) << (16 - rank);
  endfunction
  function automatic logic [7:0] lo_of(input int rank);
    return 8'(8'hE0 + 2 * (16 - rank));
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_evt(input logic [15:0] m);
    @(negedge clk) src_evt = m;
    @(negedge clk) src_evt = '0;
  endtask
  task automatic pulse_clr(input logic [15:0] m);
    @(negedge clk) pend_clr = m;
    @(negedge clk) pend_clr = '0;
  endtask
  task automatic write_en(input logic [15:0] m);
    @(negedge clk) begin en_wr = 1'b1; en_wdata = m; end
    @(negedge clk) en_wr = 1'b0;
  endtask
  task automatic vsel(input logic [7:0] pg);
    @(negedge clk) begin vsel_req = 1'b1; page = pg; end
    @(negedge clk) vsel_req = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 any_active", 8'(any_active), 8'h00);
    chk("R1 vec_hi", vec_hi, 8'h00);
    chk("R1 vec_lo", vec_lo, 8'h00);
  endtask

  task automatic t_default;
    vsel(8'h03);
    chk("R7 default lo", vec_lo, 8'hE0);
    chk("R6 page hi", vec_hi, 8'h03);
  endtask

  task automatic t_enable_gate;
    pulse_evt(rk(5));
    @(negedge clk);
    chk("R4 masked no any", 8'(any_active), 8'h00);
    vsel(8'h01);
    chk("R4 masked default", vec_lo, 8'hE0);
    write_en(rk(5));
    chk("R9 lag one cycle", 8'(any_active), 8'h00);
    @(negedge clk);
    chk("R9 any_active up", 8'(any_active), 8'h01);
    vsel(8'h01);
    chk("R6 rank5 lo", vec_lo, lo_of(5));
  endtask

  task automatic t_priority;
    write_en(16'h3E32);
    pulse_evt(rk(15));
    vsel(8'h02);
    chk("R6 rank5 beats 15", vec_lo, lo_of(5));
    pulse_evt(rk(3));
    vsel(8'h02);
    chk("R6 later rank3 wins", vec_lo, lo_of(3));
    pulse_clr(rk(3));
    vsel(8'h02);
    chk("R8 loser rank5 kept", vec_lo, lo_of(5));
    pulse_clr(rk(5));
    vsel(8'h02);
    chk("R8 loser rank15 kept", vec_lo, lo_of(15));
    write_en(rk(15));
    pulse_evt(rk(7));
    vsel(8'h02);
    chk("R4 enable write replaces", vec_lo, lo_of(15));
    write_en(16'h3E32);
    vsel(8'h02);
    chk("R2 rank7 still pending", vec_lo, lo_of(7));
    pulse_clr(16'hFFFF);
    @(negedge clk);
    chk("R3 all cleared", 8'(any_active), 8'h00);
  endtask

  task automatic t_set_clr;
    @(negedge clk) begin src_evt = rk(11); pend_clr = rk(11); end
    @(negedge clk) begin src_evt = '0; pend_clr = '0; end
    repeat (5) @(negedge clk);
    vsel(8'h04);
    chk("R3 set wins same cycle", vec_lo, lo_of(11));
    pulse_clr(rk(11));
    vsel(8'h04);
    chk("R3 clear", vec_lo, 8'hE0);
  endtask

  task automatic t_reserved;
    write_en(16'hFFFF);
    pulse_evt(~16'h3E32);
    @(negedge clk);
    chk("R5 no any_active", 8'(any_active), 8'h00);
    vsel(8'h05);
    chk("R5 default only", vec_lo, 8'hE0);
  endtask

  task automatic t_hold;
    vsel(8'h06);
    pulse_evt(rk(4));
    repeat (3) @(negedge clk);
    chk("R10 lo held", vec_lo, 8'hE0);
    chk("R10 hi held", vec_hi, 8'h06);
    chk("R9 any_active set", 8'(any_active), 8'h01);
    vsel(8'h07);
    chk("R6 rank4 lo", vec_lo, lo_of(4));
    chk("R6 new page", vec_hi, 8'h07);
  endtask

  initial begin
    src_evt = '0; pend_clr = '0; en_wr = 1'b0; en_wdata = '0;
    vsel_req = 1'b0; page = 8'h01; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_default;
    t_enable_gate;
    t_priority;
    t_set_clr;
    t_reserved;
    t_hold;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule